// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits in front of one 16-bit NOR-style word array and turns bus write cycles into flash commands. The controller follows multi-cycle unlock sequences to start a word program. It also enters an identification mode that returns fixed ID words and per-sector lock flags, and a fast-program mode in which each word needs only a set-up cycle and a data cycle. Programming can only clear bits, so the new stored word is the old word ANDed with the written data. A program runs for a fixed number of clocks. During that time every write is dropped and reads return a status word.

Reads are registered. A read strobe captures the selected source, which is the array, the ID table or the status word, into the read data output on the next clock edge. An accelerate input forces the controller from read mode into fast-program mode. A hardware reset input aborts any running program and returns the controller to read mode without touching the array.

Top module: `flash_cmd_seq`

## Requirements
- R1: After the system reset every array word reads FFFFh, busy is low, read data is 0000h and the controller is in read mode.
- R2: The cycle sequence AAh@555h, 55h@2AAh, A0h@555h, then (address, data) programs that word. Unlock addresses compare the low 11 address bits and commands compare data bits 7:0. A read strobe returns array data on the next clock edge.
- R3: A program stores the old word ANDed with the new data, so no bit goes from 0 to 1.
- R4: A write that breaks an unlock sequence returns the controller to read mode. Writes outside a valid sequence leave the array unchanged.
- R5: busy goes high on the clock edge that takes the program data cycle and stays high for exactly BUSY_CYC cycles. The array word is updated on the edge where busy falls.
- R6: Every write made while busy is high is ignored.
- R7: A read while busy returns a status word: bit 7 is the complement of bit 7 of the data being programmed, and all other bits are 0.
- R8: The sequence AAh@555h, 55h@2AAh, 90h@555h enters ID mode. Reads at in-sector offset 000h return 0001h, 001h return 227Eh, 00Eh return 2202h, 00Fh return 2200h and 003h return 0043h. A write with data F0h returns to read mode.
- R9: In ID mode, a read at in-sector offset 002h returns 0001h if the sector is locked and 0000h if it is not. The sector is the top SECT_BITS address bits, and it is locked when its bit in LOCK_MASK (default Ah) is set.
- R10: The sequence AAh@555h, 55h@2AAh, 20h@555h enters fast-program mode. There, A0h at any address followed by (address, data) programs a word, and the controller then returns to fast-program mode.
- R11: In fast-program mode, any write other than A0h or 90h is ignored and the mode is kept.
- R12: In fast-program mode, 90h followed by 00h returns the controller to read mode.
- R13: A high hwRst aborts a running program. busy is low after that edge and the target word keeps its old value.
- R14: With accel high in read mode, the controller enters fast-program mode on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low system reset; erases the array |
| hwRst | input | 1 | Synchronous hardware reset; aborts a program and returns to read mode |
| accel | input | 1 | Forces fast-program mode from read mode |
| addr | input | ADDR_W | Bus address for reads and writes |
| wrData | input | 16 | Write data |
| wrEn | input | 1 | Write strobe, one cycle per bus write |
| rdEn | input | 1 | Read strobe; rdData updates on the same edge |
| rdData | output | 16 | Registered read data |
| busy | output | 1 | High while a program is running |

## Verification
Program sequences are tried with data patterns that differ in a set of bits both ways. This separates a true AND from a plain overwrite or an OR. Broken unlock sequences and stray writes in read, ID and fast-program modes are followed by reads of the words those writes could have hit. That shows whether a mode was left or an array word was written by mistake. While a program is running, a full command sequence is written and the status word is read. A hardware reset is pulsed in the cycle after a program starts. These two cases separate an ignored write or an aborted program from one that completes. The accelerate input is tested with the fast-program entry sequence left out.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    ST_READ,
    ST_UNLK1,
    ST_UNLK2,
    ST_PGM_SETUP,
    ST_IDMODE,
    ST_FAST,
    ST_FAST_PGM,
    ST_FAST_EXIT,
    ST_BUSY
  } seqState_e;

  typedef enum logic [1:0] {
    RD_ARRAY,
    RD_ID,
    RD_STATUS
  } rdSrc_e;

  typedef struct packed {
    logic   latchPgm;
    logic   commitPgm;
    rdSrc_e rdSrc;
  } ctrlStrobe_t;

  localparam logic [10:0] UNLK1_ADDR = 11'h555;
  localparam logic [10:0] UNLK2_ADDR = 11'h2AA;
  localparam logic [7:0]  UNLK1_CMD  = 8'hAA;
  localparam logic [7:0]  UNLK2_CMD  = 8'h55;
  localparam logic [7:0]  PGM_CMD    = 8'hA0;
  localparam logic [7:0]  FAST_CMD   = 8'h20;
  localparam logic [7:0]  ID_CMD     = 8'h90;
  localparam logic [7:0]  EXIT_CMD   = 8'hF0;
  localparam logic [7:0]  FAST_DONE  = 8'h00;

  localparam logic [15:0] ID_MFR   = 16'h0001;
  localparam logic [15:0] ID_DEV1  = 16'h227E;
  localparam logic [15:0] ID_DEV2  = 16'h2202;
  localparam logic [15:0] ID_DEV3  = 16'h2200;
  localparam logic [15:0] ID_HSHK  = 16'h0043;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int BUSY_CYC = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hwRst,
  input  logic        accel,
  input  logic        wrEn,
  input  logic [10:0] unlkAddr,
  input  logic [7:0]  cmdByte,
  output ctrlStrobe_t strb,
  output logic        busy
);

  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  seqState_e        st, stNxt;
  logic             retFast, retFastNxt;
  logic [CNT_W-1:0] cnt;
  logic             isUnlk1, isUnlk2;
  logic             latchPgm, commitPgm;

  assign isUnlk1 = (unlkAddr == UNLK1_ADDR) && (cmdByte == UNLK1_CMD);
  assign isUnlk2 = (unlkAddr == UNLK2_ADDR) && (cmdByte == UNLK2_CMD);

  always_comb begin
    stNxt      = st;
    retFastNxt = retFast;
    latchPgm   = 1'b0;
    commitPgm  = 1'b0;
    unique case (st)
      ST_READ: begin
        if (accel)                  stNxt = ST_FAST;
        else if (wrEn && isUnlk1)   stNxt = ST_UNLK1;
      end
      ST_UNLK1: if (wrEn) stNxt = isUnlk2 ? ST_UNLK2 : ST_READ;
      ST_UNLK2: begin
        if (wrEn) begin
          if (unlkAddr != UNLK1_ADDR)  stNxt = ST_READ;
          else if (cmdByte == PGM_CMD) stNxt = ST_PGM_SETUP;
          else if (cmdByte == FAST_CMD) stNxt = ST_FAST;
          else if (cmdByte == ID_CMD)  stNxt = ST_IDMODE;
          else                         stNxt = ST_READ;
        end
      end
      ST_PGM_SETUP: begin
        if (wrEn) begin
          latchPgm   = 1'b1;
          retFastNxt = 1'b0;
          stNxt      = ST_BUSY;
        end
      end
      ST_IDMODE: if (wrEn && cmdByte == EXIT_CMD) stNxt = ST_READ;
      ST_FAST: begin
        if (wrEn && cmdByte == PGM_CMD)     stNxt = ST_FAST_PGM;
        else if (wrEn && cmdByte == ID_CMD) stNxt = ST_FAST_EXIT;
      end
      ST_FAST_PGM: begin
        if (wrEn) begin
          latchPgm   = 1'b1;
          retFastNxt = 1'b1;
          stNxt      = ST_BUSY;
        end
      end
      ST_FAST_EXIT: if (wrEn) stNxt = (cmdByte == FAST_DONE) ? ST_READ : ST_FAST;
      ST_BUSY: begin
        if (cnt == '0) begin
          commitPgm = 1'b1;
          stNxt     = retFast ? ST_FAST : ST_READ;
        end
      end
      default: stNxt = ST_READ;
    endcase
    if (hwRst) begin
      stNxt      = ST_READ;
      retFastNxt = 1'b0;
      latchPgm   = 1'b0;
      commitPgm  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_READ;
      retFast <= 1'b0;
      cnt     <= '0;
    end else begin
      st      <= stNxt;
      retFast <= retFastNxt;
      if (latchPgm)                    cnt <= CNT_W'(BUSY_CYC - 1);
      else if (st == ST_BUSY && cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    strb.latchPgm  = latchPgm;
    strb.commitPgm = commitPgm;
    unique case (st)
      ST_IDMODE: strb.rdSrc = RD_ID;
      ST_BUSY:   strb.rdSrc = RD_STATUS;
      default:   strb.rdSrc = RD_ARRAY;
    endcase
  end

  assign busy = (st == ST_BUSY);

  AST_HWRST_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    hwRst |=> !busy); // R13
  AST_BUSY_NO_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.latchPgm); // R6
  AST_BUSY_END_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !hwRst && !strb.commitPgm) |=> busy); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.latchPgm, strb.commitPgm})); // R5
  AST_FAST_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_FAST && wrEn && !hwRst && cmdByte != PGM_CMD && cmdByte != ID_CMD)
    |=> st == ST_FAST); // R11
  AST_ACCEL_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_READ && accel && !hwRst) |=> st == ST_FAST); // R14

endmodule

// File: rtl/flash_cmd_dpath.sv
module flash_cmd_dpath
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          MEM_AW    = 6,
  parameter int          SECT_BITS = 2,
  parameter int unsigned LOCK_MASK = 32'hA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  input  logic              rdEn,
  input  ctrlStrobe_t       strb,
  output logic [15:0]       rdData
);

  localparam int MEM_DEPTH = 1 << MEM_AW;
  localparam int SECT_CNT  = 1 << SECT_BITS;
  localparam int OFF_W     = ADDR_W - SECT_BITS;
  localparam logic [SECT_CNT-1:0] LOCK_VEC = LOCK_MASK[SECT_CNT-1:0];

  logic [15:0]          mem [MEM_DEPTH];
  logic [MEM_AW-1:0]    pgmAddr;
  logic [15:0]          pgmData;
  logic [15:0]          curWord;
  logic [15:0]          idWord;
  logic [15:0]          rdMux;
  logic [SECT_BITS-1:0] sect;
  logic [OFF_W-1:0]     secOff;

  assign curWord = mem[pgmAddr];
  assign sect    = addr[ADDR_W-1 -: SECT_BITS];
  assign secOff  = addr[OFF_W-1:0];

  always_comb begin
    unique case (secOff)
      OFF_W'(16'h000): idWord = ID_MFR;
      OFF_W'(16'h001): idWord = ID_DEV1;
      OFF_W'(16'h00E): idWord = ID_DEV2;
      OFF_W'(16'h00F): idWord = ID_DEV3;
      OFF_W'(16'h003): idWord = ID_HSHK;
      OFF_W'(16'h002): idWord = {15'd0, LOCK_VEC[sect]};
      default:         idWord = 16'h0000;
    endcase
  end

  always_comb begin
    unique case (strb.rdSrc)
      RD_ID:     rdMux = idWord;
      RD_STATUS: rdMux = {8'h00, ~pgmData[7], 7'h00};
      default:   rdMux = mem[addr[MEM_AW-1:0]];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '1;
      pgmAddr <= '0;
      pgmData <= '0;
      rdData  <= '0;
    end else begin
      if (strb.latchPgm) begin
        pgmAddr <= addr[MEM_AW-1:0];
        pgmData <= wrData;
      end
      if (strb.commitPgm) mem[pgmAddr] <= mem[pgmAddr] & pgmData;
      if (rdEn) rdData <= rdMux;
    end
  end

  AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitPgm |=> ((curWord & ~$past(curWord)) == 16'h0000)); // R3
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.latchPgm && !strb.commitPgm) |=> $stable(curWord)); // R4
  AST_STATUS_BIT7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && strb.rdSrc == RD_STATUS) |=> (rdData[7] != $past(pgmData[7]))); // R7

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          MEM_AW    = 6,
  parameter int          SECT_BITS = 2,
  parameter int unsigned LOCK_MASK = 32'hA,
  parameter int          BUSY_CYC  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwRst,
  input  logic              accel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [15:0]       rdData,
  output logic              busy
);

  ctrlStrobe_t strb;

  flash_cmd_ctrl #(.BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hwRst    (hwRst),
    .accel    (accel),
    .wrEn     (wrEn),
    .unlkAddr (addr[10:0]),
    .cmdByte  (wrData[7:0]),
    .strb     (strb),
    .busy     (busy)
  );

  flash_cmd_dpath #(
    .ADDR_W    (ADDR_W),
    .MEM_AW    (MEM_AW),
    .SECT_BITS (SECT_BITS),
    .LOCK_MASK (LOCK_MASK)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .wrData (wrData),
    .rdEn   (rdEn),
    .strb   (strb),
    .rdData (rdData)
  );

endmodule

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;

  localparam int BUSY_CYC = 8;
  localparam logic [1:0] OW = 2'd0, OR = 2'd1, OI = 2'd2;
  localparam int NV = 50;

  // {op, req, addr, data-or-expected}
  localparam logic [33:0] VEC [NV] = '{
    {OR, 4'd1,  12'h005, 16'hFFFF}, // R1 erased
    {OW, 4'd2,  12'h555, 16'h00AA}, // R2
    {OW, 4'd2,  12'h2AA, 16'h0055},
    {OW, 4'd2,  12'h555, 16'h00A0},
    {OW, 4'd2,  12'h005, 16'h1234},
    {OI, 4'd2,  12'h000, 16'h0000},
    {OR, 4'd2,  12'h005, 16'h1234},
    {OW, 4'd3,  12'h555, 16'h00AA}, // R3 AND
    {OW, 4'd3,  12'h2AA, 16'h0055},
    {OW, 4'd3,  12'h555, 16'h00A0},
    {OW, 4'd3,  12'h005, 16'hFF0F},
    {OI, 4'd3,  12'h000, 16'h0000},
    {OR, 4'd3,  12'h005, 16'h1204},
    {OW, 4'd4,  12'h555, 16'h00AA}, // R4 broken unlock
    {OW, 4'd4,  12'h2AA, 16'h0056},
    {OW, 4'd4,  12'h555, 16'h00A0},
    {OW, 4'd4,  12'h006, 16'h0000},
    {OR, 4'd4,  12'h006, 16'hFFFF},
    {OW, 4'd8,  12'h555, 16'h00AA}, // R8 ID mode
    {OW, 4'd8,  12'h2AA, 16'h0055},
    {OW, 4'd8,  12'h555, 16'h0090},
    {OR, 4'd8,  12'h000, 16'h0001},
    {OR, 4'd8,  12'h001, 16'h227E},
    {OR, 4'd8,  12'h00E, 16'h2202},
    {OR, 4'd8,  12'h00F, 16'h2200},
    {OR, 4'd8,  12'h003, 16'h0043},
    {OR, 4'd9,  12'h002, 16'h0000}, // R9 sector 0 open
    {OR, 4'd9,  12'hC02, 16'h0001}, // R9 sector 3 locked
    {OW, 4'd8,  12'h000, 16'h00F0},
    {OR, 4'd8,  12'h001, 16'hFFFF},
    {OW, 4'd10, 12'h555, 16'h00AA}, // R10 fast mode
    {OW, 4'd10, 12'h2AA, 16'h0055},
    {OW, 4'd10, 12'h555, 16'h0020},
    {OW, 4'd10, 12'h000, 16'h00A0},
    {OW, 4'd10, 12'h010, 16'h00FF},
    {OI, 4'd10, 12'h000, 16'h0000},
    {OR, 4'd10, 12'h010, 16'h00FF},
    {OW, 4'd10, 12'h011, 16'h00A0},
    {OW, 4'd10, 12'h011, 16'hF00F},
    {OI, 4'd10, 12'h000, 16'h0000},
    {OR, 4'd10, 12'h011, 16'hF00F},
    {OW, 4'd11, 12'h012, 16'h5555}, // R11 ignored
    {OW, 4'd11, 12'h555, 16'h00AA},
    {OR, 4'd11, 12'h012, 16'hFFFF},
    {OW, 4'd12, 12'h000, 16'h0090}, // R12 exit
    {OW, 4'd12, 12'h000, 16'h0000},
    {OW, 4'd12, 12'h013, 16'h00A0},
    {OW, 4'd12, 12'h013, 16'h0000},
    {OI, 4'd12, 12'h000, 16'h0000},
    {OR, 4'd12, 12'h013, 16'hFFFF}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hwRst = 1'b0;
  logic        accel = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [15:0] rdData;
  logic        busy;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_seq #(.BUSY_CYC(BUSY_CYC)) u0 (
    .clk(clk), .rstN(rstN), .hwRst(hwRst), .accel(accel), .addr(addr),
    .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData), .busy(busy)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [15:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [11:0] a, input logic [15:0] exp, input string req);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    chk(req, rdData, exp);
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < 4 * BUSY_CYC) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 busy", {15'd0, busy}, 16'h0000);
    chk("R1 rdData", rdData, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [3:0]  rq;
      logic [11:0] a;
      logic [15:0] d;
      {op, rq, a, d} = VEC[i];
      case (op)
        OW: doWrite(a, d);
        OR: doRead(a, d, $sformatf("R%0d vec%0d", rq, i));
        default: waitIdle(n);
      endcase
    end

    // R5: busy length and update when busy falls
    doWrite(12'h555, 16'h00AA); doWrite(12'h2AA, 16'h0055);
    doWrite(12'h555, 16'h00A0); doWrite(12'h024, 16'h0F0F);
    chk("R5 busy rise", {15'd0, busy}, 16'h0001);
    waitIdle(n);
    chk("R5 busy length", 16'(n), 16'(BUSY_CYC));
    doRead(12'h024, 16'h0F0F, "R5 word after busy");

    // R6 / R7: status read and writes while busy
    doWrite(12'h555, 16'h00AA); doWrite(12'h2AA, 16'h0055);
    doWrite(12'h555, 16'h00A0); doWrite(12'h020, 16'h0000);
    doRead(12'h020, 16'h0080, "R7 status bit7 set");
    doWrite(12'h555, 16'h00AA); doWrite(12'h2AA, 16'h0055);
    doWrite(12'h555, 16'h00A0); doWrite(12'h021, 16'h0000);
    waitIdle(n);
    doRead(12'h020, 16'h0000, "R6 busy word done");
    doRead(12'h021, 16'hFFFF, "R6 busy write ignored");
    doWrite(12'h555, 16'h00AA); doWrite(12'h2AA, 16'h0055);
    doWrite(12'h555, 16'h00A0); doWrite(12'h025, 16'h0080);
    doRead(12'h025, 16'h0000, "R7 status bit7 clear");
    waitIdle(n);

    // R13: hardware reset aborts
    doWrite(12'h555, 16'h00AA); doWrite(12'h2AA, 16'h0055);
    doWrite(12'h555, 16'h00A0); doWrite(12'h022, 16'h0000);
    hwRst = 1'b1;
    @(negedge clk);
    hwRst = 1'b0;
    chk("R13 busy dropped", {15'd0, busy}, 16'h0000);
    repeat (BUSY_CYC + 2) @(negedge clk);
    doRead(12'h022, 16'hFFFF, "R13 word kept");

    // R14: accelerate enters fast mode without unlock
    accel = 1'b1;
    @(negedge clk);
    doWrite(12'h023, 16'h00A0); doWrite(12'h023, 16'h1111);
    waitIdle(n);
    doRead(12'h023, 16'h1111, "R14 accel program");
    accel = 1'b0;
    doWrite(12'h000, 16'h0090); doWrite(12'h000, 16'h0000);
    doWrite(12'h023, 16'h00A0); doWrite(12'h023, 16'h0000);
    waitIdle(n);
    doRead(12'h023, 16'h1111, "R12 read mode after exit");

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule